// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar in seven byte-wide packed BCD registers: seconds, minutes, hours in 24-hour form, day of week, date, month and two-digit year. A century flag and its enable share the hours register. The block has no oscillator or divider of its own. It advances by one second on each cycle in which the single-cycle 1 Hz enable is high. Month lengths and leap years are handled in hardware.

A host loads any register through a one-cycle write port and reads any register through a combinational read port. A stop flag in the seconds register freezes the count. A read-hold input lets the host read a consistent multi-byte time. While the hold is high, a tick is remembered but not applied, so the registers never change under the reader. The remembered tick is applied as soon as the hold drops. A host write also defers a coinciding tick by one cycle, so the advance then acts on the freshly written value.

Top module: `bcd_rtc_core`

## Requirements
- R1: After a synchronous active-low reset the registers read: address 0 = 0x00, 1 = 0x00, 2 = 0x00, 3 = 0x01, 4 = 0x01, 5 = 0x01, 6 = 0x00. The stop, century-enable and century flags are all 0.
- R2: Each applied tick adds one to seconds (address 0, bits 6:0, BCD 00-59). Seconds wrap from 59 to 00 and carry into minutes (address 1, BCD 00-59). Minutes wrap from 59 to 00 and carry into hours.
- R3: Hours (address 2, bits 5:0, BCD 00-23) wrap from 23 to 00. That carry steps day of week (address 3, bits 2:0, 1-7, with 7 followed by 1) and date at the same time.
- R4: Date (address 4, BCD) returns to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 for month 02. Month 02 has 29 days when the BCD year is divisible by 4, including year 00. Month (address 5) wraps from 12 to 01 and carries into year (address 6, BCD 00-99).
- R5: When year wraps from 99 to 00, the century flag (address 2, bit 6) inverts if the century-enable flag (address 2, bit 7) is 1. If the enable is 0, the century flag does not change.
- R6: While the stop flag (address 0, bit 7) is 1, ticks have no effect and are not remembered. Writing it back to 0 resumes counting at the next tick.
- R7: While rd_hold is 1, no tick changes any register. Any number of ticks seen during the hold collapse into one pending advance. That advance is applied at the first clock edge at which rd_hold is 0.
- R8: A write loads the addressed register at the next clock edge. A tick in the same cycle as a write to addresses 1-6 is deferred and applied one cycle later, to the written value.
- R9: A write to address 0 restarts the second. A tick in the same cycle and any pending held tick are both discarded.
- R10: rd_data shows the register chosen by rd_addr in the same cycle. Bits outside each field read 0, and address 7 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz_i | input | 1 | One-cycle pulse once per second |
| rd_hold_i | input | 1 | High while the host reads the time registers |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read register address |
| rd_data_o | output | 8 | Read data for rd_addr_i |

## Verification
Two functions of this block can fall in the same cycle. The first case is a host write and a one-second tick: the bench pulses both together, once on the minutes register and once on the seconds register. It judges that the write lands and the tick is applied one cycle later, or is dropped in the seconds case. The second case is a hold release meeting a pending tick: the bench sends several ticks under rd_hold, checks that nothing moved, then checks for exactly one advance at the release edge. A near-exhaustive sweep walks every second of an hour and every midnight over four years, with the century boundary and a leap year included, against an arithmetic model.

// File: rtl/rtc_pkg.sv
// Shared constants, register selects and BCD helpers for the time counter.
// Assumes all fields are stored as 8-bit packed BCD.
package rtc_pkg;
    localparam int NUM_FIELDS = 7;
    localparam int FIELD_W    = 8;
    localparam int ADDR_W     = $clog2(NUM_FIELDS + 1);

    // Register select; the order is the host's sequential access order.
    typedef enum logic [ADDR_W-1:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_WDAY = 3'd3,
        SEL_MDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6,
        SEL_VOID = 3'd7
    } reg_sel_e;

    // Value a field takes after reset and after its wrap.
    function automatic logic [FIELD_W-1:0] field_first(input int idx);
        if (idx == 3 || idx == 4 || idx == 5) return 8'h01;
        return 8'h00;
    endfunction

    // Bits a field stores; the others read as zero.
    function automatic logic [FIELD_W-1:0] field_mask(input int idx);
        case (idx)
            0, 1:    return 8'h7F;
            2, 4:    return 8'h3F;
            3:       return 8'h07;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Two-digit BCD increment without wrap handling.
    function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisible by 4: ten counts as 2 modulo 4, so use the tens LSB doubled.
    function automatic logic is_leap_bcd(input logic [FIELD_W-1:0] yr);
        logic [1:0] rem;
        rem = {yr[4], 1'b0} + yr[1:0];
        return (rem == 2'b00);
    endfunction

    // Last date of a BCD month.
    function automatic logic [FIELD_W-1:0] month_last(input logic [FIELD_W-1:0] mo,
                                                      input logic leap);
        case (mo)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
// One BCD counter field: loads from the host, steps on inc_i, and wraps to
// FIRST after reaching max_i. Assumes ld_i and inc_i are never both high.
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter int           W     = FIELD_W,
    parameter logic [W-1:0] FIRST = '0,
    parameter logic [W-1:0] MASK  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         inc_i,
    input  logic [W-1:0] max_i,
    output logic [W-1:0] val_o,
    output logic         carry_o
);
    logic [W-1:0] val_q;

    // Carry out when stepping past the top of the range.
    always_comb carry_o = inc_i && (val_q == max_i);

    // Field register: host load, else step or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= FIRST;
        else if (ld_i)   val_q <= ld_val_i & MASK;
        else if (inc_i)  val_q <= carry_o ? FIRST : bcd_inc(val_q);
    end

    assign val_o = val_q;

    AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i && val_q == max_i) |=> (val_q == FIRST)); // R2
endmodule

// File: rtl/rtc_tick_gate.sv
// Decides when the counters advance. Ticks seen under a read hold or a write
// are kept as one pending advance; stop and a seconds write discard them.
module rtc_tick_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rd_hold_i,
    input  logic wr_i,
    input  logic sec_wr_i,
    input  logic stop_i,
    output logic adv_o
);
    logic pending_q;
    logic hold_eff;

    // A write behaves as a one-cycle hold so it never races an advance.
    always_comb hold_eff = rd_hold_i || wr_i;

    // Advance when free to, on a fresh or remembered tick.
    always_comb adv_o = !hold_eff && !stop_i && (tick_i || pending_q);

    // Pending flag: set by a held tick, cleared when applied or discarded.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pending_q <= 1'b0;
        else if (sec_wr_i || stop_i) pending_q <= 1'b0;
        else if (hold_eff)           pending_q <= pending_q || tick_i;
        else                         pending_q <= 1'b0;
    end

    AST_HELD_TICK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold_i && tick_i && !sec_wr_i && !stop_i)
        |=> (rd_hold_i || wr_i || stop_i || adv_o)); // R7
    AST_SEC_WR_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr_i |=> (adv_o == tick_i || !adv_o)); // R9
    AST_NO_ADV_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !sec_wr_i) |=> !adv_o); // R6
endmodule

// File: rtl/rtc_calendar_chain.sv
// The seven BCD fields and their carry wiring, including month length and
// leap-year selection for the date field. Assumes adv_i and wr_en_i exclusive.
module rtc_calendar_chain
    import rtc_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                adv_i,
    input  logic                                wr_en_i,
    input  logic [ADDR_W-1:0]                   wr_sel_i,
    input  logic [FIELD_W-1:0]                  wr_data_i,
    output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  fields_o,
    output logic                                year_roll_o
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] val;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] maxv;
    logic [NUM_FIELDS-1:0]              inc;
    logic [NUM_FIELDS-1:0]              carry;

    // Upper limit of each field; the date limit follows month and year.
    always_comb begin
        maxv[SEL_SEC]  = 8'h59;
        maxv[SEL_MIN]  = 8'h59;
        maxv[SEL_HOUR] = 8'h23;
        maxv[SEL_WDAY] = 8'h07;
        maxv[SEL_MDAY] = month_last(val[SEL_MON], is_leap_bcd(val[SEL_YEAR]));
        maxv[SEL_MON]  = 8'h12;
        maxv[SEL_YEAR] = 8'h99;
    end

    // Carry routing: midnight steps both weekday and date.
    always_comb begin
        inc[SEL_SEC]  = adv_i;
        inc[SEL_MIN]  = carry[SEL_SEC];
        inc[SEL_HOUR] = carry[SEL_MIN];
        inc[SEL_WDAY] = carry[SEL_HOUR];
        inc[SEL_MDAY] = carry[SEL_HOUR];
        inc[SEL_MON]  = carry[SEL_MDAY];
        inc[SEL_YEAR] = carry[SEL_MON];
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        rtc_bcd_field #(
            .W     (FIELD_W),
            .FIRST (field_first(g)),
            .MASK  (field_mask(g))
        ) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (wr_en_i && (wr_sel_i == ADDR_W'(g))),
            .ld_val_i (wr_data_i),
            .inc_i    (inc[g]),
            .max_i    (maxv[g]),
            .val_o    (val[g]),
            .carry_o  (carry[g])
        );
    end

    assign fields_o    = val;
    assign year_roll_o = carry[SEL_YEAR];

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        carry[SEL_WDAY] |=> (val[SEL_WDAY] == 8'h01)); // R3
    AST_FEB_LEAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[SEL_MDAY] && val[SEL_MON] == 8'h02 && val[SEL_MDAY] == 8'h28
         && is_leap_bcd(val[SEL_YEAR])) |=> (val[SEL_MDAY] == 8'h29)); // R4
    AST_FEB_COMMON: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[SEL_MDAY] && val[SEL_MON] == 8'h02 && val[SEL_MDAY] == 8'h28
         && !is_leap_bcd(val[SEL_YEAR])) |=> (val[SEL_MDAY] == 8'h01
                                              && val[SEL_MON] == 8'h03)); // R4
endmodule

// File: rtl/bcd_rtc_core.sv
// Top of the BCD time and calendar counter. Holds the stop, century-enable
// and century flags, and drives the host read mux. Assumes tick_1hz_i is a
// single-cycle pulse in the clk domain.
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_1hz_i,
    input  logic               rd_hold_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [FIELD_W-1:0] rd_data_o
);
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields;
    logic sec_wr, hour_wr, adv, year_roll;
    logic stop_q, ceb_q, cb_q;

    // Decode writes that also touch the flag bits.
    always_comb begin
        sec_wr  = wr_en_i && (wr_addr_i == SEL_SEC);
        hour_wr = wr_en_i && (wr_addr_i == SEL_HOUR);
    end

    rtc_tick_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_1hz_i),
        .rd_hold_i (rd_hold_i),
        .wr_i      (wr_en_i),
        .sec_wr_i  (sec_wr),
        .stop_i    (stop_q),
        .adv_o     (adv)
    );

    rtc_calendar_chain u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv_i       (adv),
        .wr_en_i     (wr_en_i),
        .wr_sel_i    (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .fields_o    (fields),
        .year_roll_o (year_roll)
    );

    // Stop flag lives in bit 7 of the seconds register.
    always_ff @(posedge clk) begin
        if (!rst_n)      stop_q <= 1'b0;
        else if (sec_wr) stop_q <= wr_data_i[7];
    end

    // Century enable and century flag; the flag flips on year rollover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ceb_q <= 1'b0;
            cb_q  <= 1'b0;
        end else if (hour_wr) begin
            ceb_q <= wr_data_i[7];
            cb_q  <= wr_data_i[6];
        end else if (year_roll && ceb_q) begin
            cb_q  <= ~cb_q;
        end
    end

    // Host read mux with flag bits overlaid on their registers.
    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i != SEL_VOID) rd_data_o = fields[rd_addr_i];
        if (rd_addr_i == SEL_SEC)  rd_data_o = rd_data_o | {stop_q, 7'b0};
        if (rd_addr_i == SEL_HOUR) rd_data_o = rd_data_o | {ceb_q, cb_q, 6'b0};
    end

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !wr_en_i) |=> $stable(fields)); // R6
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold_i && !wr_en_i) |=> $stable(fields)); // R7
    AST_CENTURY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ceb_q && !hour_wr) |=> $stable(cb_q)); // R5
    AST_VOID_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == SEL_VOID) |-> (rd_data_o == 8'h00)); // R10
endmodule

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/100ps
module test_bcd_rtc_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       hold = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state, kept as plain integers.
    int s, m, h, dw, dt, mo, yr;
    bit stp, ceb, cb;

    always #2.5 clk = ~clk;

    bcd_rtc_core i_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_1hz_i(tick), .rd_hold_i(hold),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(input int mon, input int year);
        if (mon == 2) return (year % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] expect_reg(input int a);
        case (a)
            0: return {stp, 7'(bcd(s))};
            1: return bcd(m);
            2: return {ceb, cb, 6'(bcd(h))};
            3: return 8'(dw);
            4: return bcd(dt);
            5: return bcd(mo);
            6: return bcd(yr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        s = 0; m = 0; h = 0; dw = 1; dt = 1; mo = 1; yr = 0;
        stp = 0; ceb = 0; cb = 0;
    endtask

    task automatic model_tick();
        if (stp) return;
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0; h++;
                if (h == 24) begin
                    h = 0;
                    dw = (dw == 7) ? 1 : dw + 1;
                    dt++;
                    if (dt > dim(mo, yr)) begin
                        dt = 1; mo++;
                        if (mo == 13) begin
                            mo = 1; yr++;
                            if (yr == 100) begin
                                yr = 0;
                                if (ceb) cb = ~cb;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check_regs(input string tag);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.2;
            checks++;
            if (rd_data !== expect_reg(a)) begin
                errors++;
                $display("FAIL %s addr %0d: act=%h exp=%h", tag, a, rd_data, expect_reg(a));
            end
        end
    endtask

    task automatic write_reg(input int a, input logic [7:0] d, input bit with_tick);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d; tick = with_tick;
        step();
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check_regs("R1 R10 reset");

        // R2: every second of an hour plus a little, from 00:00:00.
        for (int i = 0; i < 3700; i++) begin
            pulse_tick();
            model_tick();
            check_regs("R2 seconds sweep");
        end

        // R3 R4 R5: every midnight from 98-01-01 through four years, century on.
        write_reg(6, 8'h98, 0); yr = 98;
        write_reg(5, 8'h01, 0); mo = 1;
        write_reg(4, 8'h01, 0); dt = 1;
        write_reg(3, 8'h01, 0); dw = 1;
        ceb = 1; cb = 0;
        for (int d = 0; d < 1461; d++) begin
            write_reg(0, 8'h59, 0); s = 59;
            write_reg(1, 8'h59, 0); m = 59;
            write_reg(2, {ceb, cb, 6'h23}, 0); h = 23;
            pulse_tick();
            model_tick();
            check_regs("R3 R4 R5 midnight sweep");
        end

        // R5: century enable off, century flag must hold.
        ceb = 0; cb = 1;
        write_reg(6, 8'h99, 0); yr = 99;
        write_reg(5, 8'h12, 0); mo = 12;
        write_reg(4, 8'h31, 0); dt = 31;
        write_reg(2, {1'b0, 1'b1, 6'h23}, 0); h = 23;
        write_reg(1, 8'h59, 0); m = 59;
        write_reg(0, 8'h59, 0); s = 59;
        pulse_tick();
        model_tick();
        check_regs("R5 century locked");

        // R6: stop freezes, clearing resumes.
        write_reg(0, 8'h80 | bcd(20), 0); s = 20; stp = 1;
        for (int i = 0; i < 5; i++) begin
            pulse_tick();
            check_regs("R6 stopped");
        end
        write_reg(0, bcd(20), 0); stp = 0;
        check_regs("R6 released");
        pulse_tick();
        model_tick();
        check_regs("R6 resumed");

        // R7: three ticks under hold collapse to one advance at release.
        hold = 1'b1;
        for (int i = 0; i < 3; i++) begin
            pulse_tick();
            step();
        end
        check_regs("R7 held");
        hold = 1'b0;
        step();
        model_tick();
        check_regs("R7 release applies one");
        step();
        check_regs("R7 no second advance");

        // R8: minutes write and tick together; tick applied next cycle.
        write_reg(1, 8'h30, 1); m = 30;
        check_regs("R8 write lands first");
        step();
        model_tick();
        check_regs("R8 deferred tick applied");

        // R9: seconds write with a coinciding tick drops the tick.
        write_reg(0, 8'h05, 1); s = 5;
        check_regs("R9 write with tick");
        step();
        check_regs("R9 tick dropped");

        // R9: a pending held tick is dropped by a seconds write.
        hold = 1'b1;
        pulse_tick();
        write_reg(0, 8'h07, 0); s = 7;
        hold = 1'b0;
        step();
        check_regs("R9 pending dropped");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule